// File: doc/BRIEF.md
# Four-Way Bus Routing Switch

This block is the routing switch that sits at each corner of a tile in a mesh of add-multiply cells. It carries data between tiles that are not next to each other. It collects twelve k-bit buses: one arriving from each of the four neighbouring switches, and the low-half and high-half result buses of the four logic cells around it (north-west, north-east, south-west, south-east). From these it drives one bus toward each side: North goes to the row above, South to the row below, East to the column on the right, West to the column on the left.

Each outgoing bus comes from its own eight-way bus selector. One 3-bit code switches the whole bus, so no bit is configured on its own. The eight candidates for an output are the four neighbour-switch buses plus the low and high buses of the two cells on that output's side. The four 3-bit codes sit in a 12-bit chain that is loaded one bit per clock while the load enable is high. Routes are computed offline and shifted in before data flows. The data path itself has no register, so a routed bus follows its source in the same cycle.

Top module: `sbox_route_top`

## Requirements
- R1: While reset is asserted and after its release, all four select codes are 0, so every output carries the bus from the north neighbour switch (`nb_n_i`).
- R2: With `cfg_en` high, each rising clock edge shifts `cfg_bit` into the chain. After twelve such edges the first bit shifted in is the top bit of the North code. The codes sit in the order North, South, East, West, and each is sent top bit first.
- R3: With `cfg_en` low, clock edges leave every code unchanged whatever `cfg_bit` does.
- R4: On every output, codes 0, 1, 2 and 3 select the whole bus from the north, south, east and west neighbour switch respectively.
- R5: North output: code 4 selects the north-west cell's low bus, 5 its high bus, 6 the north-east cell's low bus, 7 its high bus.
- R6: South output: codes 4/5 select the south-west cell's low/high bus, and 6/7 the south-east cell's low/high bus.
- R7: East output: codes 4/5 select the north-east cell's low/high bus, and 6/7 the south-east cell's low/high bus.
- R8: West output: codes 4/5 select the north-west cell's low/high bus, and 6/7 the south-west cell's low/high bus.
- R9: The outputs are combinational in the data inputs. A change on a selected input shows on the output without any clock edge.
- R10: While codes are being shifted in, each output follows the code held after the latest edge. It shows that code's candidate bus as it stands in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Asynchronous active-low reset, clears all codes |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_bit | input | 1 | Serial configuration bit |
| nb_n_i | input | BUS_W | Bus from the switch to the north |
| nb_s_i | input | BUS_W | Bus from the switch to the south |
| nb_e_i | input | BUS_W | Bus from the switch to the east |
| nb_w_i | input | BUS_W | Bus from the switch to the west |
| cell_nw_lo_i | input | BUS_W | Low result bus of the north-west cell |
| cell_nw_hi_i | input | BUS_W | High result bus of the north-west cell |
| cell_ne_lo_i | input | BUS_W | Low result bus of the north-east cell |
| cell_ne_hi_i | input | BUS_W | High result bus of the north-east cell |
| cell_sw_lo_i | input | BUS_W | Low result bus of the south-west cell |
| cell_sw_hi_i | input | BUS_W | High result bus of the south-west cell |
| cell_se_lo_i | input | BUS_W | Low result bus of the south-east cell |
| cell_se_hi_i | input | BUS_W | High result bus of the south-east cell |
| out_n_o | output | BUS_W | Bus toward the row above |
| out_s_o | output | BUS_W | Bus toward the row below |
| out_e_o | output | BUS_W | Bus toward the column on the right |
| out_w_o | output | BUS_W | Bus toward the column on the left |

## Verification
Two things can happen in the same cycle here: a configuration shift that moves every code by one bit, and new data arriving on all twelve inputs. The bench provokes this by loading each code with fresh, pairwise-distinct data every cycle of the load. After each edge it judges all four outputs against a queue model of the shifted bits and its own side-cell table. It also changes inputs between edges to show that the data path needs no clock.

// File: rtl/sbox_pkg.sv
`timescale 1ns/1ps
package sbox_pkg;

    localparam int SB_DIRS  = 4;
    localparam int SB_CAND  = 8;
    localparam int SB_SEL_W = $clog2(SB_CAND);
    localparam int SB_NB    = 4;
    localparam int SB_CELLS = 4;

    typedef enum int {
        DIR_N = 0,
        DIR_S = 1,
        DIR_E = 2,
        DIR_W = 3
    } sb_dir_e;

    localparam int CELL_NW = 0;
    localparam int CELL_NE = 1;
    localparam int CELL_SW = 2;
    localparam int CELL_SE = 3;

    // Cell feeding the slot-th pair of candidates (slot 0: codes 4/5, slot 1: codes 6/7)
    function automatic int side_cell(int dir, int slot);
        int c;
        case (dir)
            DIR_N:   c = (slot == 0) ? CELL_NW : CELL_NE;
            DIR_S:   c = (slot == 0) ? CELL_SW : CELL_SE;
            DIR_E:   c = (slot == 0) ? CELL_NE : CELL_SE;
            default: c = (slot == 0) ? CELL_NW : CELL_SW;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sbox_cfg_chain.sv
`timescale 1ns/1ps
module sbox_cfg_chain #(
    parameter int FIELDS = 4,
    parameter int SEL_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en_i,
    input  logic             bit_i,
    output logic [SEL_W-1:0] sel_o [FIELDS]
);

    localparam int TOTAL = FIELDS * SEL_W;

    logic [TOTAL-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else if (shift_en_i) begin
            chain_q <= {chain_q[TOTAL-2:0], bit_i};
        end
    end

    // field 0 holds the earliest bits shifted in
    for (genvar f = 0; f < FIELDS; f++) begin : g_field
        assign sel_o[f] = chain_q[(FIELDS-1-f)*SEL_W +: SEL_W];
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> chain_q == '0);

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en_i |=> $stable(chain_q));

endmodule

// File: rtl/sbox_bus_mux.sv
`timescale 1ns/1ps
module sbox_bus_mux #(
    parameter int BUS_W = 16,
    parameter int CAND  = 8,
    localparam int SEL_W = $clog2(CAND)
) (
    input  logic [BUS_W-1:0] cand_i [CAND],
    input  logic [SEL_W-1:0] sel_i,
    output logic [BUS_W-1:0] bus_o
);

    always_comb begin
        bus_o = cand_i[sel_i];
    end

endmodule

// File: rtl/sbox_route_top.sv
`timescale 1ns/1ps
module sbox_route_top
    import sbox_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_bit,
    input  logic [BUS_W-1:0] nb_n_i,
    input  logic [BUS_W-1:0] nb_s_i,
    input  logic [BUS_W-1:0] nb_e_i,
    input  logic [BUS_W-1:0] nb_w_i,
    input  logic [BUS_W-1:0] cell_nw_lo_i,
    input  logic [BUS_W-1:0] cell_nw_hi_i,
    input  logic [BUS_W-1:0] cell_ne_lo_i,
    input  logic [BUS_W-1:0] cell_ne_hi_i,
    input  logic [BUS_W-1:0] cell_sw_lo_i,
    input  logic [BUS_W-1:0] cell_sw_hi_i,
    input  logic [BUS_W-1:0] cell_se_lo_i,
    input  logic [BUS_W-1:0] cell_se_hi_i,
    output logic [BUS_W-1:0] out_n_o,
    output logic [BUS_W-1:0] out_s_o,
    output logic [BUS_W-1:0] out_e_o,
    output logic [BUS_W-1:0] out_w_o
);

    logic [BUS_W-1:0]    nb_bus  [SB_NB];
    logic [BUS_W-1:0]    cell_lo [SB_CELLS];
    logic [BUS_W-1:0]    cell_hi [SB_CELLS];
    logic [BUS_W-1:0]    out_bus [SB_DIRS];
    logic [SB_SEL_W-1:0] sel     [SB_DIRS];

    assign nb_bus[DIR_N] = nb_n_i;
    assign nb_bus[DIR_S] = nb_s_i;
    assign nb_bus[DIR_E] = nb_e_i;
    assign nb_bus[DIR_W] = nb_w_i;

    assign cell_lo[CELL_NW] = cell_nw_lo_i;
    assign cell_hi[CELL_NW] = cell_nw_hi_i;
    assign cell_lo[CELL_NE] = cell_ne_lo_i;
    assign cell_hi[CELL_NE] = cell_ne_hi_i;
    assign cell_lo[CELL_SW] = cell_sw_lo_i;
    assign cell_hi[CELL_SW] = cell_sw_hi_i;
    assign cell_lo[CELL_SE] = cell_se_lo_i;
    assign cell_hi[CELL_SE] = cell_se_hi_i;

    sbox_cfg_chain #(
        .FIELDS (SB_DIRS),
        .SEL_W  (SB_SEL_W)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en_i (cfg_en),
        .bit_i      (cfg_bit),
        .sel_o      (sel)
    );

    for (genvar d = 0; d < SB_DIRS; d++) begin : g_dir
        localparam int CA = side_cell(d, 0);
        localparam int CB = side_cell(d, 1);

        logic [BUS_W-1:0] cand [SB_CAND];

        always_comb begin
            for (int s = 0; s < SB_NB; s++) begin
                cand[s] = nb_bus[s];
            end
            cand[4] = cell_lo[CA];
            cand[5] = cell_hi[CA];
            cand[6] = cell_lo[CB];
            cand[7] = cell_hi[CB];
        end

        sbox_bus_mux #(
            .BUS_W (BUS_W),
            .CAND  (SB_CAND)
        ) u_mux (
            .cand_i (cand),
            .sel_i  (sel[d]),
            .bus_o  (out_bus[d])
        );

        always_comb begin
            if (rst_n) begin
                // R4
                if (sel[d] < 3'd4) begin
                    nb_route_chk: assert (out_bus[d] == nb_bus[sel[d][1:0]]);
                end
                // R5
                if (sel[d] == 3'd4) begin
                    near_lo_route_chk: assert (out_bus[d] == cell_lo[CA]);
                end
                // R6
                if (sel[d] == 3'd7) begin
                    far_hi_route_chk: assert (out_bus[d] == cell_hi[CB]);
                end
            end
        end
    end

    assign out_n_o = out_bus[DIR_N];
    assign out_s_o = out_bus[DIR_S];
    assign out_e_o = out_bus[DIR_E];
    assign out_w_o = out_bus[DIR_W];

    // R2
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> sel[DIR_W][0] == $past(cfg_bit));

    // R2
    field_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> sel[DIR_N] == {$past(sel[DIR_N][1:0]), $past(sel[DIR_S][2])});

endmodule

// File: tb/sbox_route_top_tb_top.sv
`timescale 1ns/1ps
module sbox_route_top_tb_top;

    localparam int W = 16;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         rst_n;
    logic         cfg_en;
    logic         cfg_bit;
    logic [W-1:0] nb   [4];
    logic [W-1:0] clo  [4];
    logic [W-1:0] chi  [4];
    logic [W-1:0] o_n, o_s, o_e, o_w;

    int  checks = 0;
    int  fails  = 0;
    bit  finished = 0;
    bit  shifted_last = 0;
    bit  in_reset_window = 1;
    bit  model_q [$];

    // cells: 0 NW, 1 NE, 2 SW, 3 SE ; per output: cell for codes 4/5 and for 6/7
    int cell_a [4] = '{0, 2, 1, 0};
    int cell_b [4] = '{1, 3, 3, 2};

    sbox_route_top #(.BUS_W(W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_en       (cfg_en),
        .cfg_bit      (cfg_bit),
        .nb_n_i       (nb[0]),
        .nb_s_i       (nb[1]),
        .nb_e_i       (nb[2]),
        .nb_w_i       (nb[3]),
        .cell_nw_lo_i (clo[0]),
        .cell_nw_hi_i (chi[0]),
        .cell_ne_lo_i (clo[1]),
        .cell_ne_hi_i (chi[1]),
        .cell_sw_lo_i (clo[2]),
        .cell_sw_hi_i (chi[2]),
        .cell_se_lo_i (clo[3]),
        .cell_se_hi_i (chi[3]),
        .out_n_o      (o_n),
        .out_s_o      (o_s),
        .out_e_o      (o_e),
        .out_w_o      (o_w)
    );

    function automatic int code_of(int d);
        int v = 0;
        foreach (model_q[i]) v = ((v << 1) | int'(model_q[i])) & 12'hFFF;
        return (v >> (3 * (3 - d))) & 7;
    endfunction

    function automatic logic [W-1:0] expect_of(int d);
        int c = code_of(d);
        case (c)
            0, 1, 2, 3: return nb[c];
            4: return clo[cell_a[d]];
            5: return chi[cell_a[d]];
            6: return clo[cell_b[d]];
            default: return chi[cell_b[d]];
        endcase
    endfunction

    function automatic logic [W-1:0] actual_of(int d);
        case (d)
            0: return o_n;
            1: return o_s;
            2: return o_e;
            default: return o_w;
        endcase
    endfunction

    function automatic string code_tag(int d);
        if (code_of(d) < 4) return "R4";
        case (d)
            0: return "R5";
            1: return "R6";
            2: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check_one(int d, string tag);
        logic [W-1:0] a = actual_of(d);
        logic [W-1:0] e = expect_of(d);
        checks++;
        if (a !== e) begin
            fails++;
            $display("FAIL %s out%0d code=%0d actual=%h expected=%h t=%0t",
                     tag, d, code_of(d), a, e, $time);
        end
    endtask

    task automatic check_all(string tag);
        for (int d = 0; d < 4; d++) check_one(d, tag);
    endtask

    task automatic set_data(int salt);
        for (int i = 0; i < 4; i++) begin
            nb[i]  = W'(((i + 1) * 16'h1357) ^ (salt * 16'h0F1D));
            clo[i] = W'(((i + 5) * 16'h1357) ^ (salt * 16'h0F1D));
            chi[i] = W'(((i + 9) * 16'h1357) ^ (salt * 16'h0F1D));
        end
    endtask

    // reference model: queue of shifted bits, newest at the back
    always @(posedge clk) begin
        if (!rst_n) begin
            model_q.delete();
            shifted_last = 0;
        end else begin
            shifted_last = cfg_en;
            if (cfg_en) begin
                model_q.push_back(cfg_bit);
                if (model_q.size() > 12) void'(model_q.pop_front());
            end
        end
    end

    // per-cycle comparison, away from the clock edge
    always @(negedge clk) begin
        #1;
        if (!finished) begin
            for (int d = 0; d < 4; d++) begin
                if (in_reset_window) check_one(d, "R1");
                else if (shifted_last) check_one(d, "R10");
                else check_one(d, code_tag(d));
            end
        end
    end

    task automatic load_cfg(int cn, int cs, int ce, int cw, int salt);
        int word = (cn << 9) | (cs << 6) | (ce << 3) | cw;
        for (int b = 11; b >= 0; b--) begin
            @(negedge clk);
            cfg_en  = 1'b1;
            cfg_bit = word[b];
            set_data(salt + b);
        end
        @(negedge clk);
        cfg_en = 1'b0;
    endtask

    initial begin
        #(5.0 * 50000);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n   = 1'b0;
        cfg_en  = 1'b0;
        cfg_bit = 1'b0;
        set_data(0);
        repeat (2) @(negedge clk);
        set_data(3);
        cfg_en  = 1'b1;
        cfg_bit = 1'b1;
        @(negedge clk);
        cfg_en = 1'b0;
        rst_n  = 1'b1;
        @(negedge clk);
        #1;
        // R1: codes still zero after release
        check_all("R1");
        in_reset_window = 0;

        // R3: toggling bit with enable low changes nothing
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            cfg_bit = k[0];
            set_data(20 + k);
        end
        @(negedge clk);
        #1;
        check_all("R3");

        // every code on every output, three data patterns each
        for (int c = 0; c < 8; c++) begin
            load_cfg(c, c, c, c, 40 + c * 16);
            for (int p = 0; p < 3; p++) begin
                @(negedge clk);
                set_data(200 + c * 4 + p);
            end
        end

        // R2: distinct codes land in their own fields
        load_cfg(5, 2, 7, 1, 300);
        #1;
        check_all("R2");
        checks++;
        if (o_n !== chi[0] || o_s !== nb[2] || o_e !== chi[3] || o_w !== nb[1]) begin
            fails++;
            $display("FAIL R2 fields actual=%h/%h/%h/%h expected=%h/%h/%h/%h",
                     o_n, o_s, o_e, o_w, chi[0], nb[2], chi[3], nb[1]);
        end

        // R3: enable low, edges pass, routes kept
        cfg_bit = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check_all("R3");

        // R9: input change between edges shows without a clock
        load_cfg(6, 4, 3, 0, 400);
        #1.5;
        set_data(77);
        #0.5;
        check_all("R9");
        checks++;
        if (o_n !== clo[1]) begin
            fails++;
            $display("FAIL R9 north actual=%h expected=%h", o_n, clo[1]);
        end

        // R10: shifting while data moves every cycle
        load_cfg(3, 7, 4, 6, 500);
        repeat (2) @(negedge clk);
        #1;
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule